// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This block sits in a transmit path in front of the MAC. An outgoing frame arrives one byte per beat and is stored in an internal frame buffer. Separately, a five-word sideband header describes the frame. When the header enables offload, the block computes a 16-bit ones-complement checksum while the frame is written into the buffer. The sum runs from a start offset to the end of the frame and also takes a seed value from the header. The complemented result is then patched, big-endian, into the frame at an insertion offset as the buffer is streamed out.

The block also has a transmit control word that holds three settings: transmit enable, jumbo mode and VLAN mode. Three rules decide whether a frame is sent:
- With transmit disabled, frames are swallowed.
- Frames too large for the buffer are thrown away.
- With jumbo and VLAN modes both off, frames of VLAN-tagged size are dropped.

Each released frame produces a one-cycle completion pulse and adds its length to a 64-bit byte counter.

Top module: `txcs_top`

## Requirements
- R1: After reset, and after any control write with bit 31 set, the control word reads 0x5800_0000 (bit 30 jumbo, bit 28 transmit enable, bit 27 VLAN). A reset write also discards any partly received frame. A control write without bit 31 stores the written value unchanged.
- R2: While control bit 28 is clear, input bytes are accepted (in_ready stays high) but are discarded: no output byte, no completion pulse, no change to tx_bytes.
- R3: A header is taken only when exactly 5 words arrive, the last one marked by hdr_last. Any other count raises hdr_err for one cycle and leaves the previous header in force.
- R4: When bit 0 of header word 0 is clear, the frame is sent out byte for byte unchanged.
- R5: With offload on, the checksum is formed from the seed (header word 2 bits 15:0) plus big-endian 16-bit words. The words start at the start offset (header word 1 bits 31:16) and run to the frame end. An odd final byte is paired with a zero low byte. The sum is folded end-around to 16 bits and then inverted.
- R6: The checksum high byte replaces the frame byte at the insertion offset (header word 1 bits 15:0) and the low byte replaces the byte at the insertion offset plus 1. Positions at or beyond the frame length are not written.
- R7: A frame longer than DEPTH bytes (default 4096) is discarded completely. The frame that follows is handled normally.
- R8: When control bits 30 and 27 are both clear, frames of 1519 to 1522 bytes are dropped. Frames of 1518 or 1523 bytes still go out, and so does a 1520-byte frame when either of those bits is set.
- R9: Each released frame gives exactly one tx_done pulse one cycle long, and tx_bytes grows by the frame length in that same cycle.
- R10: tx_done shows after the second clock edge following acceptance of the last input byte. The first output byte follows one edge later, then one byte per cycle, with out_last on the final byte. in_ready is low from the last accepted input byte until the final output byte appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Transmit control word write strobe |
| ctl_wdata | input | 32 | Transmit control word write value |
| ctl_o | output | 32 | Current transmit control word |
| hdr_valid | input | 1 | Sideband header word valid |
| hdr_word | input | 32 | Sideband header word |
| hdr_last | input | 1 | Marks the final header word |
| hdr_err | output | 1 | One-cycle pulse on a header of wrong length |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final frame byte |
| in_ready | output | 1 | Block can take a frame byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte, checksum patched in |
| out_last | output | 1 | Marks the final output byte |
| tx_done | output | 1 | Frame released pulse |
| tx_bytes | output | 64 | Running total of released bytes |

## Verification
A fault in the running sum or in its parity tracking shows up at the insertion offset of the very next offloaded frame. The two patched bytes come out wrong while every other byte still matches. A write pointer that is wrong after a drop, an overflow or a control reset shifts or truncates the next frame, so out_last lands in the wrong cycle or bytes come out that were never sent. A bad drop decision shows up in the same frame: an unexpected output byte appears, or tx_done and tx_bytes fall behind the model. The checks run on every clock and as soon as each frame settles.

// File: rtl/txcs_pkg.sv
package txcs_pkg;
    localparam int CTL_VLAN  = 27;
    localparam int CTL_EN    = 28;
    localparam int CTL_JUMBO = 30;
    localparam int CTL_RST   = 31;
    localparam logic [31:0] CTL_INIT = 32'h5800_0000;
    localparam int HDR_WORDS = 5;
    localparam int STD_MAX   = 1518;
    localparam int TAG_MAX   = 1522;

    typedef enum logic [1:0] {ST_FILL = 2'd0, ST_FOLD = 2'd1, ST_SEND = 2'd2} st_e;

    typedef struct packed {
        logic        en;
        logic [15:0] start;
        logic [15:0] ins;
        logic [15:0] seed;
    } hdr_t;

    // End-around fold of a 32-bit partial sum, then complement.
    function automatic logic [15:0] fold_inv(input logic [31:0] s);
        logic [16:0] s1;
        logic [15:0] s2;
        s1 = {1'b0, s[31:16]} + {1'b0, s[15:0]};
        s2 = s1[15:0] + {15'b0, s1[16]};
        return ~s2;
    endfunction
endpackage

// File: rtl/txcs_hdr.sv
module txcs_hdr
    import txcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid,
    input  logic [31:0] word,
    input  logic        last,
    output hdr_t        hdr_o,
    output logic        err_o
);
    typedef struct packed {
        logic [2:0]  cnt;
        logic        en_s;
        logic [31:0] offs_s;
        logic [15:0] seed_s;
        hdr_t        cur;
        logic        err;
    } hs_t;

    hs_t q, n;

    always_comb begin
        n     = q;
        n.err = 1'b0;
        if (valid) begin
            case (q.cnt)
                3'd0:    n.en_s   = word[0];
                3'd1:    n.offs_s = word;
                3'd2:    n.seed_s = word[15:0];
                default: ;
            endcase
            if (last) begin
                n.cnt = '0;
                if (q.cnt == 3'(HDR_WORDS - 1)) begin
                    n.cur.en    = q.en_s;
                    n.cur.start = q.offs_s[31:16];
                    n.cur.ins   = q.offs_s[15:0];
                    n.cur.seed  = q.seed_s;
                end else begin
                    n.err = 1'b1;
                end
            end else if (q.cnt != 3'(HDR_WORDS + 1)) begin
                n.cnt = q.cnt + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign hdr_o = q.cur;
    assign err_o = q.err;

    // R3: an error pulse only follows a terminating header word
    a_r3_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(valid && last));
endmodule

// File: rtl/txcs_sum.sv
module txcs_sum (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        add,
    input  logic [15:0] pos,
    input  logic [15:0] start,
    input  logic [7:0]  data,
    output logic [31:0] acc_o
);
    logic [31:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (add && pos >= start) begin
            // even distance from start: high byte of a big-endian word
            if (pos[0] ^ start[0]) acc_d = acc_q + {24'b0, data};
            else                   acc_d = acc_q + {16'b0, data, 8'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/txcs_buf.sv
module txcs_buf #(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/txcs_top.sv
module txcs_top
    import txcs_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_o,
    input  logic        hdr_valid,
    input  logic [31:0] hdr_word,
    input  logic        hdr_last,
    output logic        hdr_err,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        tx_done,
    output logic [63:0] tx_bytes
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        st_e           st;
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [PW-1:0] len;
        logic          drop;
        logic [15:0]   csum;
        logic [31:0]   ctl;
        logic          done;
        logic [63:0]   bytes;
        logic          ovalid;
        logic [7:0]    odata;
        logic          olast;
    } ts_t;

    ts_t q, n;

    hdr_t          hdr;
    logic [31:0]   acc;
    logic          mem_we, sum_add, sum_clr;
    logic [7:0]    rdata;
    logic [PW-1:0] len_now;
    logic          size_bad;
    logic [31:0]   rp32, ins32;

    txcs_hdr i_hdr (
        .clk(clk), .rst_n(rst_n), .valid(hdr_valid), .word(hdr_word),
        .last(hdr_last), .hdr_o(hdr), .err_o(hdr_err)
    );

    txcs_sum i_sum (
        .clk(clk), .rst_n(rst_n), .clr(sum_clr), .add(sum_add),
        .pos(16'(q.wptr)), .start(hdr.start), .data(in_data), .acc_o(acc)
    );

    txcs_buf #(.DEPTH(DEPTH)) i_buf (
        .clk(clk), .we(mem_we), .waddr(q.wptr[AW-1:0]), .wdata(in_data),
        .raddr(q.rptr[AW-1:0]), .rdata(rdata)
    );

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        n.ovalid = 1'b0;
        n.olast  = 1'b0;
        mem_we   = 1'b0;
        sum_add  = 1'b0;
        sum_clr  = 1'b0;
        len_now  = q.wptr + 1'b1;
        size_bad = !q.ctl[CTL_JUMBO] && !q.ctl[CTL_VLAN] &&
                   (32'(len_now) > STD_MAX) && (32'(len_now) <= TAG_MAX);
        rp32     = 32'(q.rptr);
        ins32    = {16'b0, hdr.ins};

        case (q.st)
            ST_FILL: begin
                if (in_valid && q.ctl[CTL_EN]) begin
                    if (q.drop) begin
                        if (in_last) n.drop = 1'b0;
                    end else if (32'(q.wptr) == DEPTH) begin
                        sum_clr = 1'b1;
                        n.wptr  = '0;
                        n.drop  = !in_last;
                    end else begin
                        mem_we = 1'b1;
                        if (in_last && size_bad) begin
                            sum_clr = 1'b1;
                            n.wptr  = '0;
                        end else if (in_last) begin
                            sum_add = 1'b1;
                            n.len   = len_now;
                            n.wptr  = '0;
                            n.st    = ST_FOLD;
                        end else begin
                            sum_add = 1'b1;
                            n.wptr  = len_now;
                        end
                    end
                end
            end
            ST_FOLD: begin
                n.csum  = fold_inv(acc + {16'b0, hdr.seed});
                sum_clr = 1'b1;
                n.done  = 1'b1;
                n.bytes = q.bytes + 64'(q.len);
                n.rptr  = '0;
                n.st    = ST_SEND;
            end
            ST_SEND: begin
                n.ovalid = 1'b1;
                n.odata  = rdata;
                if (hdr.en && rp32 == ins32)              n.odata = q.csum[15:8];
                else if (hdr.en && rp32 == ins32 + 32'd1) n.odata = q.csum[7:0];
                n.olast = (q.rptr == q.len - 1'b1);
                n.rptr  = q.rptr + 1'b1;
                if (n.olast) n.st = ST_FILL;
            end
            default: n.st = ST_FILL;
        endcase

        if (ctl_we) begin
            n.ctl = ctl_wdata;
            if (ctl_wdata[CTL_RST]) begin
                n.ctl   = CTL_INIT;
                n.wptr  = '0;
                n.drop  = 1'b0;
                sum_clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.ctl <= CTL_INIT;
        end else begin
            q <= n;
        end
    end

    assign ctl_o     = q.ctl;
    assign in_ready  = (q.st == ST_FILL);
    assign out_valid = q.ovalid;
    assign out_data  = q.odata;
    assign out_last  = q.olast;
    assign tx_done   = q.done;
    assign tx_bytes  = q.bytes;

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);
    // R9: the byte counter moves up together with the pulse
    a_r9_bytes_grow: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> tx_bytes > $past(tx_bytes));
    // R10: first output byte follows the completion pulse by one cycle
    a_r10_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> out_valid);
    // R10: input is held off while bytes other than the last are shown
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !in_ready);
    // R7: the write pointer never passes the buffer size
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        32'(q.wptr) <= DEPTH);
endmodule

// File: tb/test_txcs_top.sv
module test_txcs_top;
    localparam int DEPTH = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_o;
    logic        hdr_valid = 1'b0;
    logic [31:0] hdr_word = '0;
    logic        hdr_last = 1'b0;
    logic        hdr_err;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready, out_valid, out_last, tx_done;
    logic [7:0]  out_data;
    logic [63:0] tx_bytes;

    always #5 clk = ~clk;

    txcs_top #(.DEPTH(DEPTH)) i_txcs_top (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_o(ctl_o), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
        .hdr_last(hdr_last), .hdr_err(hdr_err), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .tx_done(tx_done), .tx_bytes(tx_bytes)
    );

    int checks = 0, errors = 0;
    // reference model state
    logic [31:0] m_ctl = 32'h5800_0000;
    logic        m_en = 1'b0;
    int          m_start = 0, m_ins = 0;
    logic [15:0] m_seed = '0;
    longint      m_bytes = 0;
    int          m_done = 0, done_cnt = 0;
    logic [7:0]  exp_d[$];
    bit          exp_l[$];
    string       exp_r[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic [15:0] ref_csum(input logic [7:0] f[$], input int st, input logic [15:0] sd);
        longint s = longint'(sd);
        for (int i = st; i < f.size(); i += 2)
            s += longint'({f[i], ((i + 1 < f.size()) ? f[i+1] : 8'h00)});
        while ((s >> 16) != 0) s = (s & 64'hffff) + (s >> 16);
        return ~s[15:0];
    endfunction

    // compared on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_done) done_cnt++;
            if (ctl_o != m_ctl) chk(0, "R1 control word", ctl_o, m_ctl);
            if (out_valid) begin
                if (exp_d.size() == 0) begin
                    chk(0, "R2 R7 R8 unexpected output byte", out_data, 0);
                end else begin
                    logic [7:0] d;
                    bit l;
                    string r;
                    d = exp_d.pop_front();
                    l = exp_l.pop_front();
                    r = exp_r.pop_front();
                    chk(out_data == d, r, out_data, d);
                    chk(out_last == l, {r, " last flag"}, out_last, l);
                end
            end
        end
    end

    task automatic wr_ctl(input logic [31:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(posedge clk);
        #1;
        ctl_we = 1'b0;
        m_ctl = v[31] ? 32'h5800_0000 : v;
    endtask

    task automatic send_hdr(input int nw, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            hdr_valid = 1'b1;
            hdr_word  = (i == 0) ? w0 : (i == 1) ? w1 : (i == 2) ? w2 : 32'hdead_0000 + 32'(i);
            hdr_last  = (i == nw - 1);
            @(posedge clk);
            #1;
            hdr_valid = 1'b0;
            hdr_last  = 1'b0;
            if (i == nw - 1) chk(hdr_err == (nw != 5), "R3 header length error", hdr_err, nw != 5);
        end
        if (nw == 5) begin
            m_en = w0[0];
            m_start = int'(w1[31:16]);
            m_ins = int'(w1[15:0]);
            m_seed = w2[15:0];
        end
    endtask

    task automatic put(input logic [7:0] b, input bit last);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data = b;
        in_last = last;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    task automatic send_frame(input int len, input int k, input string tag, input bit timing);
        logic [7:0] f[$];
        logic [7:0] e[$];
        bit pass;
        longint b0;
        int d0;
        for (int i = 0; i < len; i++) f.push_back(8'((i * 13 + k * 29 + 5) & 255));
        pass = m_ctl[28] && (len <= DEPTH) &&
               !(!m_ctl[30] && !m_ctl[27] && len > 1518 && len <= 1522);
        b0 = m_bytes;
        d0 = m_done;
        if (pass) begin
            e = f;
            if (m_en) begin
                logic [15:0] c;
                c = ref_csum(f, m_start, m_seed);
                if (m_ins < len) e[m_ins] = c[15:8];
                if (m_ins + 1 < len) e[m_ins+1] = c[7:0];
            end
            foreach (e[i]) begin
                exp_d.push_back(e[i]);
                exp_l.push_back(i == len - 1);
                exp_r.push_back(tag);
            end
            m_bytes += len;
            m_done++;
        end
        for (int i = 0; i < len; i++) put(f[i], i == len - 1);
        if (timing) begin
            @(negedge clk);
            chk(!tx_done && !out_valid, "R10 fold cycle idle", {tx_done, out_valid}, 0);
            @(negedge clk);
            chk(tx_done && !out_valid, "R10 done before data", {tx_done, out_valid}, 2);
            chk(!in_ready, "R10 input held off", in_ready, 0);
            @(negedge clk);
            chk(out_valid, "R10 first byte", out_valid, 1);
        end
        while (exp_d.size() != 0 || !in_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(tx_bytes == 64'(m_bytes), {tag, " R9 byte count"}, tx_bytes, m_bytes);
        chk(done_cnt == m_done, {tag, " R9 done pulses"}, done_cnt, m_done);
        if (!pass) begin
            chk(tx_bytes == 64'(b0) && done_cnt == d0, {tag, " dropped frame has no effect"}, tx_bytes, b0);
            chk(in_ready, {tag, " still accepting"}, in_ready, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ctl_o == 32'h5800_0000, "R1 reset control word", ctl_o, 32'h5800_0000);
        chk(in_ready && !out_valid && !tx_done && !hdr_err, "R1 reset outputs",
            {in_ready, out_valid, tx_done, hdr_err}, 4'b1000);
        chk(tx_bytes == 0, "R1 reset byte count", tx_bytes, 0);

        // R4 no offload, with R10 timing
        send_hdr(5, 32'h0, {16'd2, 16'd4}, 32'h0000_1111);
        send_frame(20, 1, "R4 passthrough", 1'b1);

        // R5 R6 offload, even start
        send_hdr(5, 32'h1, {16'd14, 16'd24}, 32'h0000_1234);
        send_frame(40, 2, "R5 R6 even start", 1'b0);
        // R5 odd start, odd length
        send_hdr(5, 32'h1, {16'd15, 16'd6}, 32'h0000_fedc);
        send_frame(41, 3, "R5 odd start odd length", 1'b0);
        // R6 insertion at last byte and beyond end
        send_hdr(5, 32'h1, {16'd0, 16'd29}, 32'h0000_0001);
        send_frame(30, 4, "R6 insert at final byte", 1'b0);
        send_hdr(5, 32'h1, {16'd0, 16'd200}, 32'h0000_0001);
        send_frame(30, 5, "R6 insert beyond end", 1'b0);

        // R3 wrong lengths keep previous header
        send_hdr(4, 32'h0, {16'd3, 16'd3}, 32'h0);
        send_hdr(6, 32'h0, {16'd5, 16'd5}, 32'h0);
        send_frame(33, 6, "R3 previous header kept", 1'b0);

        // R2 transmit disabled
        wr_ctl(32'h4800_0000);
        send_frame(25, 7, "R2 disabled", 1'b0);
        wr_ctl(32'h8000_0000);
        chk(ctl_o == 32'h5800_0000, "R1 reset by write", ctl_o, 32'h5800_0000);

        // R8 size rule
        wr_ctl(32'h1000_0000);
        send_frame(1519, 8, "R8 1519 dropped", 1'b0);
        send_frame(1522, 9, "R8 1522 dropped", 1'b0);
        send_frame(1518, 10, "R8 1518 sent", 1'b0);
        send_frame(1523, 11, "R8 1523 sent", 1'b0);
        wr_ctl(32'h1800_0000);
        send_frame(1520, 12, "R8 VLAN lets 1520 through", 1'b0);
        wr_ctl(32'h5000_0000);
        send_frame(1521, 13, "R8 jumbo lets 1521 through", 1'b0);

        // R7 overflow then normal frame
        send_frame(DEPTH + 1, 14, "R7 oversize dropped", 1'b0);
        send_frame(18, 15, "R7 next frame normal", 1'b0);

        // R1 control reset discards a partial frame
        for (int i = 0; i < 10; i++) put(8'haa, 1'b0);
        wr_ctl(32'h8000_0000);
        send_frame(12, 16, "R1 partial frame discarded", 1'b0);

        finish_run();
    end
endmodule